// File: doc/BRIEF.md
# Clustered Machine Timer Compare Bank

This block is the machine-timer device of one cluster of harts. It holds a 64-bit compare register for each hart of its cluster and a free-running 64-bit time counter that steps once per enable tick. Each hart has its own timer interrupt line. That line is high whenever the time value has reached the hart's compare value.

Software reaches the block over a simple memory-mapped bus with a request side and a response side. Each request carries a word address, a write flag, write data and the index of the cluster the requesting hart belongs to. The compare registers of all clusters share one flat address range. Each cluster owns a block of 8 bytes per hart, and the blocks sit back to back in cluster order, so every device in the system decodes the same map.

A build-time switch decides whether a hart from another cluster may touch this cluster's compare registers. When the switch is off, a write from another cluster is dropped and a read from another cluster returns zero.

Top module: `ctb_bank`

## Requirements
- R1: While reset is asserted and right after it is released, every compare register reads all ones, the time value is zero, all interrupt lines are low and no response is pending.
- R2: Hart n of this cluster has its compare register at byte address CLUSTER_ID*8*HARTS + 8*n. The low 32 bits are at that address and the high 32 bits at that address plus 4. A write changes only the addressed half.
- R3: A request to an address outside this cluster's compare block and outside the time words affects no compare register, and a read there returns zero. This includes addresses in another cluster's block.
- R4: With ALLOW_FOREIGN = 0, a request whose cluster index differs from CLUSTER_ID leaves this cluster's compare registers unchanged, and a read from it returns zero.
- R5: With ALLOW_FOREIGN = 1, a request from any cluster index reads and writes this cluster's compare registers exactly as an own-cluster request does.
- R6: The time value rises by exactly one in each cycle in which tick is high, and holds otherwise. Its low word reads at byte address 8*HARTS*CLUSTERS and its high word 4 bytes above that. Any cluster may read it, and writes there are ignored. A read returns the value from before that cycle's tick.
- R7: Interrupt line n is high exactly when the time value is greater than or equal to hart n's compare value, both taken as unsigned. The line follows a tick or a compare write on the next cycle.
- R8: A request is accepted in a cycle where req_valid and req_ready are both high, and req_ready = !rsp_valid || rsp_ready. Every accepted request raises rsp_valid in the next cycle. The response carries the read data for a read and zero for a write, and it holds with unchanged data until rsp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time counter enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address, bits [1:0] ignored |
| req_wdata | input | 32 | Write data |
| req_cluster | input | CID_W | Cluster index of the requesting hart |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Read data, zero for writes and blocked reads |
| irq | output | HARTS | Timer interrupt per hart of this cluster |

## Verification
Any corrupted compare half or time value shows up within one cycle on that hart's interrupt line, as long as the corruption moves the value across the current time. Otherwise it shows up on the next read of that word. A filter that lets a foreign write through changes the interrupt line and the later read-back of the register. A wrong handshake shows the same cycle on req_ready, or the next cycle on rsp_valid.

The reference model tracks every compare half, the time value and the pending response for two instances, one with the foreign switch off and one with it on. It compares all outputs every cycle, under directed and random traffic with random back-pressure.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  // Bytes occupied by one hart's compare register in the flat map.
  localparam int unsigned CTB_SLOT_BYTES = 8;

  typedef enum logic [1:0] {
    CTB_SEL_NONE = 2'd0,
    CTB_SEL_CMP  = 2'd1,
    CTB_SEL_TIME = 2'd2
  } ctb_sel_e;
endpackage

// File: rtl/ctb_decode.sv
module ctb_decode
  import ctb_pkg::*;
#(
  parameter int HARTS         = 2,
  parameter int CLUSTERS      = 2,
  parameter int CLUSTER_ID    = 1,
  parameter bit ALLOW_FOREIGN = 1'b0,
  parameter int ADDR_W        = 8,
  parameter int CID_W         = 1,
  parameter int HART_W        = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CID_W-1:0]  cluster,
  output ctb_sel_e          sel,
  output logic [HART_W-1:0] hart,
  output logic              hi
);
  localparam int unsigned WIN_BYTES = CTB_SLOT_BYTES * HARTS;
  localparam int unsigned OWN_LO    = CLUSTER_ID * WIN_BYTES;
  localparam int unsigned OWN_HI    = OWN_LO + WIN_BYTES;
  localparam int unsigned TIME_OFF  = WIN_BYTES * CLUSTERS;
  localparam logic [31:0] OWN_LO_V  = 32'(OWN_LO);
  localparam logic [31:0] OWN_HI_V  = 32'(OWN_HI);
  localparam logic [31:0] TIME_V    = 32'(TIME_OFF);

  logic [31:0] a32;
  logic [31:0] offs;
  logic        in_win;
  logic        permit;
  logic        is_time;

  always_comb begin
    a32     = 32'(addr) & 32'hFFFF_FFFC;
    offs    = a32 - OWN_LO_V;
    in_win  = (a32 >= OWN_LO_V) && (a32 < OWN_HI_V);
    permit  = ALLOW_FOREIGN || (32'(cluster) == 32'(CLUSTER_ID));
    is_time = (a32[31:3] == TIME_V[31:3]);
    hart    = offs[HART_W+2:3];
    hi      = a32[2];
    if (in_win && permit)  sel = CTB_SEL_CMP;
    else if (is_time)      sel = CTB_SEL_TIME;
    else                   sel = CTB_SEL_NONE;
  end
endmodule

// File: rtl/ctb_timebase.sv
module ctb_timebase #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [TIME_W-1:0] time_val
);
  logic [TIME_W-1:0] time_q;
  logic [TIME_W-1:0] time_d;

  always_comb begin
    time_d = time_q;
    if (tick) time_d = time_q + TIME_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  assign time_val = time_q;
endmodule

// File: rtl/ctb_cmp_reg.sv
module ctb_cmp_reg #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [31:0]       wdata,
  input  logic [TIME_W-1:0] time_val,
  output logic [TIME_W-1:0] cmp_val,
  output logic              irq
);
  logic [TIME_W-1:0] cmp_q;
  logic [TIME_W-1:0] cmp_d;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo) cmp_d[31:0]        = wdata;
    if (wr_hi) cmp_d[TIME_W-1:32] = wdata[TIME_W-33:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '1;
    else        cmp_q <= cmp_d;
  end

  assign cmp_val = cmp_q;
  assign irq     = (time_val >= cmp_q);
endmodule

// File: rtl/ctb_bank.sv
module ctb_bank
  import ctb_pkg::*;
#(
  parameter int  HARTS         = 2,
  parameter int  CLUSTERS      = 2,
  parameter int  CLUSTER_ID    = 1,
  parameter bit  ALLOW_FOREIGN = 1'b0,
  parameter int  ADDR_W        = 8,
  localparam int CID_W         = (CLUSTERS > 1) ? $clog2(CLUSTERS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [CID_W-1:0]  req_cluster,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [HARTS-1:0]  irq
);
  localparam int TIME_W = 64;
  localparam int HART_W = (HARTS > 1) ? $clog2(HARTS) : 1;

  ctb_sel_e          sel;
  logic [HART_W-1:0] hart;
  logic              hi;
  logic              accept;
  logic [TIME_W-1:0] time_q;
  logic [TIME_W-1:0] cmp_val [HARTS];
  logic [31:0]       rd_mux;
  logic              rsp_valid_q, rsp_valid_d;
  logic [31:0]       rsp_rdata_q, rsp_rdata_d;

  ctb_decode #(
    .HARTS(HARTS), .CLUSTERS(CLUSTERS), .CLUSTER_ID(CLUSTER_ID),
    .ALLOW_FOREIGN(ALLOW_FOREIGN), .ADDR_W(ADDR_W), .CID_W(CID_W),
    .HART_W(HART_W)
  ) u_decode (
    .addr(req_addr), .cluster(req_cluster), .sel(sel), .hart(hart), .hi(hi)
  );

  ctb_timebase #(.TIME_W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .time_val(time_q)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  for (genvar h = 0; h < HARTS; h++) begin : g_hart
    logic hit;
    assign hit = accept && req_write && (sel == CTB_SEL_CMP) &&
                 (hart == HART_W'(h));
    ctb_cmp_reg #(.TIME_W(TIME_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(hit && !hi), .wr_hi(hit && hi),
      .wdata(req_wdata), .time_val(time_q),
      .cmp_val(cmp_val[h]), .irq(irq[h])
    );
  end

  always_comb begin
    case (sel)
      CTB_SEL_CMP:  rd_mux = hi ? cmp_val[hart][63:32] : cmp_val[hart][31:0];
      CTB_SEL_TIME: rd_mux = hi ? time_q[63:32] : time_q[31:0];
      default:      rd_mux = '0;
    endcase
  end

  always_comb begin
    rsp_valid_d = rsp_valid_q;
    rsp_rdata_d = rsp_rdata_q;
    if (accept) begin
      rsp_valid_d = 1'b1;
      rsp_rdata_d = req_write ? 32'd0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/ctb_bank_chk.sv
module ctb_bank_chk #(
  parameter int HARTS         = 2,
  parameter int CLUSTER_ID    = 1,
  parameter bit ALLOW_FOREIGN = 1'b0,
  parameter int CID_W         = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [CID_W-1:0] req_cluster,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic [HARTS-1:0] irq,
  input logic [63:0]      time_val
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R8

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R8

  AST_NO_ACCEPT_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R8

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (time_val == $past(time_val) + 64'd1)); // R6

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_val)); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(acc && req_write)) |=> $stable(irq)); // R7

  AST_FOREIGN_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ((ALLOW_FOREIGN == 1'b0) && acc && req_write && !tick &&
     (32'(req_cluster) != 32'(CLUSTER_ID))) |=> $stable(irq)); // R4
endmodule

bind ctb_bank ctb_bank_chk #(
  .HARTS(HARTS), .CLUSTER_ID(CLUSTER_ID),
  .ALLOW_FOREIGN(ALLOW_FOREIGN), .CID_W(CID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_cluster(req_cluster), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .irq(irq), .time_val(time_q)
);

// File: tb/tb_ctb_bank.sv
module tb_ctb_bank;
  localparam int CLK_PERIOD = 10;
  localparam int H   = 2;
  localparam int C   = 2;
  localparam int CID = 1;
  localparam int AW  = 8;
  localparam int TOFF = 8 * H * C;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, req_valid, req_write, rsp_ready;
  logic [AW-1:0] req_addr;
  logic [31:0] req_wdata;
  logic [0:0] req_cluster;
  logic [1:0] o_ready, o_valid;
  logic [31:0] o_rdata [2];
  logic [H-1:0] o_irq [2];

  logic [63:0] m_cmp [2][H];
  logic [63:0] m_time;
  logic m_rv [2];
  logic [31:0] m_rd [2];

  int vecs = 0;
  int fails = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ctb_bank #(.HARTS(H), .CLUSTERS(C), .CLUSTER_ID(CID), .ALLOW_FOREIGN(1'b0), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid), .req_ready(o_ready[0]),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_cluster(req_cluster),
    .rsp_valid(o_valid[0]), .rsp_ready(rsp_ready), .rsp_rdata(o_rdata[0]), .irq(o_irq[0]));

  ctb_bank #(.HARTS(H), .CLUSTERS(C), .CLUSTER_ID(CID), .ALLOW_FOREIGN(1'b1), .ADDR_W(AW)) dut_open (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid), .req_ready(o_ready[1]),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_cluster(req_cluster),
    .rsp_valid(o_valid[1]), .rsp_ready(rsp_ready), .rsp_rdata(o_rdata[1]), .irq(o_irq[1]));

  function automatic bit owns(int inst, int a, int cl);
    return (a >= CID*8*H) && (a < (CID+1)*8*H) && (inst == 1 || cl == CID);
  endfunction

  function automatic logic [31:0] model_read(int inst, int a, int cl);
    if ((a >> 3) == (TOFF >> 3)) return a[2] ? m_time[63:32] : m_time[31:0];
    if (owns(inst, a, cl)) begin
      int hh = (a - CID*8*H) >> 3;
      return a[2] ? m_cmp[inst][hh][63:32] : m_cmp[inst][hh][31:0];
    end
    return 32'd0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      for (int h = 0; h < H; h++) m_cmp[i][h] = '1;
      m_rv[i] = 1'b0;
      m_rd[i] = 32'd0;
    end
    m_time = 64'd0;
  endtask

  task automatic model_step();
    int a = int'(req_addr) & 32'hFC;
    int cl = int'(req_cluster);
    for (int i = 0; i < 2; i++) begin
      bit acc = req_valid && (!m_rv[i] || rsp_ready);
      if (acc) begin
        m_rd[i] = req_write ? 32'd0 : model_read(i, a, cl);
        m_rv[i] = 1'b1;
        if (req_write && owns(i, a, cl)) begin
          int hh = (a - CID*8*H) >> 3;
          if (a[2]) m_cmp[i][hh][63:32] = req_wdata;
          else      m_cmp[i][hh][31:0]  = req_wdata;
        end
      end else if (rsp_ready) begin
        m_rv[i] = 1'b0;
      end
    end
    if (tick) m_time = m_time + 64'd1;
  endtask

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < 2; i++) begin
      logic [H-1:0] ei;
      bit er;
      for (int h = 0; h < H; h++) ei[h] = (m_time >= m_cmp[i][h]);
      er = !m_rv[i] || rsp_ready;
      chk(o_irq[i] === ei, $sformatf("irq inst%0d", i), 64'(o_irq[i]), 64'(ei));
      chk(o_ready[i] === er, $sformatf("req_ready inst%0d", i), 64'(o_ready[i]), 64'(er));
      chk(o_valid[i] === m_rv[i], $sformatf("rsp_valid inst%0d", i), 64'(o_valid[i]), 64'(m_rv[i]));
      if (m_rv[i])
        chk(o_rdata[i] === m_rd[i], $sformatf("rsp_rdata inst%0d", i), 64'(o_rdata[i]), 64'(m_rd[i]));
    end
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic op(bit wr, int a, logic [31:0] d, int cl, bit rr, bit tk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    req_cluster = 1'(cl); rsp_ready = rr; tick = tk;
    cycle();
    req_valid = 1'b0; rsp_ready = 1'b1; tick = 1'b0;
  endtask

  task automatic idle(int n, bit tk);
    for (int k = 0; k < n; k++) begin
      req_valid = 1'b0; rsp_ready = 1'b1; tick = tk;
      cycle();
    end
    tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_cluster = '0; rsp_ready = 1'b1;
    model_reset();
    // R1: reset state, with tick driven to show the counter stays zero
    tag = "R1";
    tick = 1'b1;
    repeat (3) @(negedge clk);
    compare();
    tick = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    op(1'b0, 8'h10, 0, CID, 1'b1, 1'b0);   // all-ones low half after reset
    op(1'b0, 8'h1C, 0, CID, 1'b1, 1'b0);   // all-ones high half after reset

    // R2: hart 0 at 0x10, hart 1 at 0x18, halves written separately
    tag = "R2";
    op(1'b1, 8'h14, 32'd0, CID, 1'b1, 1'b0);
    op(1'b0, 8'h10, 0, CID, 1'b1, 1'b0);
    op(1'b0, 8'h14, 0, CID, 1'b1, 1'b0);
    op(1'b1, 8'h10, 32'd6, CID, 1'b1, 1'b0);
    op(1'b0, 8'h10, 0, CID, 1'b1, 1'b0);
    op(1'b1, 8'h1C, 32'd0, CID, 1'b1, 1'b0);
    op(1'b0, 8'h18, 0, CID, 1'b1, 1'b0);

    // R7: irq of hart 0 rises when time reaches 6
    tag = "R7";
    idle(8, 1'b1);
    op(1'b1, 8'h10, 32'd100, CID, 1'b1, 1'b0);   // larger compare drops irq
    idle(2, 1'b0);

    // R3: other cluster's block and unmapped addresses
    tag = "R3";
    op(1'b1, 8'h00, 32'd1, CID, 1'b1, 1'b0);
    op(1'b1, 8'h08, 32'd1, 0, 1'b1, 1'b0);
    op(1'b0, 8'h00, 0, 0, 1'b1, 1'b0);
    op(1'b1, 8'h30, 32'd1, CID, 1'b1, 1'b0);
    op(1'b0, 8'h30, 0, CID, 1'b1, 1'b0);
    op(1'b0, 8'h18, 0, CID, 1'b1, 1'b0);

    // R4 and R5: foreign requester against blocking and open instances
    tag = "R4";
    op(1'b1, 8'h18, 32'd2, 0, 1'b1, 1'b0);
    op(1'b0, 8'h18, 0, 0, 1'b1, 1'b0);
    tag = "R5";
    op(1'b0, 8'h1C, 0, 0, 1'b1, 1'b0);
    op(1'b0, 8'h18, 0, CID, 1'b1, 1'b0);
    idle(2, 1'b0);

    // R6: time read, writes ignored, pre-tick value returned
    tag = "R6";
    op(1'b0, 8'h20, 0, 0, 1'b1, 1'b1);
    op(1'b1, 8'h20, 32'hFFFF, CID, 1'b1, 1'b0);
    op(1'b0, 8'h20, 0, CID, 1'b1, 1'b0);
    op(1'b0, 8'h24, 0, 0, 1'b1, 1'b0);

    // R8: back-pressure holds the response and stalls requests
    tag = "R8";
    op(1'b0, 8'h20, 0, CID, 1'b0, 1'b1);
    op(1'b0, 8'h10, 0, CID, 1'b0, 1'b0);
    op(1'b1, 8'h18, 32'd3, CID, 1'b0, 1'b0);
    op(1'b1, 8'h18, 32'd4, CID, 1'b1, 1'b0);
    idle(2, 1'b0);

    // Random traffic; tag follows the dominant behaviour of each vector
    for (int n = 0; n < 3000; n++) begin
      int a = $urandom_range(0, 15) * 4;
      int cl = $urandom_range(0, 1);
      bit wr = $urandom_range(0, 1);
      logic [31:0] d = ($urandom_range(0, 3) == 0) ? 32'd0 : 32'($urandom_range(0, 4000));
      tag = (a >= TOFF) ? "R6" : (cl != CID) ? "R4" : wr ? "R2" : "R7";
      req_valid = ($urandom_range(0, 3) != 0);
      req_write = wr; req_addr = AW'(a); req_wdata = d; req_cluster = 1'(cl);
      rsp_ready = ($urandom_range(0, 3) != 0);
      tick = $urandom_range(0, 1);
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule